// File: doc/BRIEF.md
# Buffered Pipeline Stage with Stall Buffer

This block is one registered stage placed between an upstream producer and a downstream consumer. Each side uses a strobe/busy handshake. A word moves across an edge when its strobe is high and the matching busy is low, so with no busy asserted one word passes on every clock. Each accepted word goes through a fixed combinational transform on its way into the output register. By default the transform adds a constant of one.

The busy signal sent upstream is registered. Because of this, the producer cannot see a stall in time to hold back the word it has already committed. That word is taken anyway, transformed, and parked in a one-entry side buffer. On the same edge the upstream busy goes high. When the consumer stops being busy, the parked word moves into the output register ahead of any newer input, and upstream busy drops again on that edge. The block neither loses a word nor sends one twice.

Top module: `skid_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stage clears its output strobe `dn_valid`, the side-buffer occupancy and the upstream busy `up_busy`. All of them read 0 after the edge.
- R2: A word is accepted from upstream only at an edge where `up_valid` is 1 and `up_busy` is 0. A word is handed downstream only at an edge where `dn_valid` is 1 and `dn_busy` is 0.
- R3: With `dn_busy` low and `up_valid` held high, a word is accepted and delivered on every clock. A word accepted at an edge appears on `dn_data` with `dn_valid` high right after that same edge.
- R4: The delivered value is the accepted `up_data` plus `XF_CONST`, modulo 2^`WIDTH`. With the defaults (`WIDTH`=16, `XF_CONST`=1, add mode) 16'hFFFF is delivered as 16'h0000.
- R5: While `dn_valid` and `dn_busy` are both high, `dn_valid` stays high and `dn_data` does not change at the next edge.
- R6: A word accepted at an edge where the output register is occupied and `dn_busy` is high is kept in the side buffer, and `up_busy` reads 1 right after that edge.
- R7: At the first edge where `dn_busy` is low while `up_busy` is 1, the buffered word is moved onto `dn_data` and `up_busy` returns to 0. No newer word overtakes it.
- R8: Every accepted word is delivered exactly once, in acceptance order, under any pattern of `up_valid` and `dn_busy`.
- R9: `up_data` has no effect at an edge where `up_valid` is 0 or `up_busy` is 1.
- R10: `dn_valid` falls after the edge that hands off the last word when neither the side buffer nor the input supplies another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Upstream strobe: `up_data` carries a word |
| up_data | input | WIDTH | Upstream data word |
| up_busy | output | 1 | Registered busy toward upstream; high while the side buffer is full |
| dn_valid | output | 1 | Downstream strobe: `dn_data` carries a word |
| dn_data | output | WIDTH | Transformed data word toward downstream |
| dn_busy | input | 1 | Downstream busy; holds the output word in place |

## Verification
The bench builds the stage with its default parameters: 16-bit data, add mode, constant 1. It can therefore predict every delivered value as input plus one. Feeding 16'hFFFF brings the wrap to zero within reach. The directed scenarios cover a burst that enters a stall and leaves it, an unbroken stream, and data that changes while the stage is stalled or the strobe is low. A long pseudo-random run then mixes strobe and busy patterns to exercise the side buffer filling and draining back to back. Throughout, an ordered scoreboard compares each handed-off word with the queue of accepted words.

// File: rtl/skid_stage_pkg.sv
// Package skid_stage_pkg
// Holds the types shared by the stage and its sub-blocks.
// Assumes nothing beyond IEEE 1800-2017 packages.
package skid_stage_pkg;

    // Selects the fixed operation applied on the data path.
    typedef enum logic {
        XF_ADD = 1'b0,
        XF_XOR = 1'b1
    } xf_op_e;

endpackage

// File: rtl/skid_xform.sv
// Module skid_xform
// Purely combinational transform on the data path. The operation is fixed
// at elaboration: add a constant (wrapping) or xor with a constant.
// Assumes the caller registers the result; no state is kept here.
module skid_xform
    import skid_stage_pkg::*;
#(
    parameter int              WIDTH    = 16,
    parameter xf_op_e          XF_OP    = XF_ADD,
    parameter logic [WIDTH-1:0] XF_CONST = 1
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (XF_OP == XF_ADD) begin : g_add
            // Wrapping addition of the constant.
            always_comb dout = din + XF_CONST;
        end else begin : g_xor
            // Bitwise xor with the constant.
            always_comb dout = din ^ XF_CONST;
        end
    endgenerate

endmodule

// File: rtl/skid_side_buf.sv
// Module skid_side_buf
// One-entry side buffer that parks a word which arrived while the output
// register could not advance. Its occupancy flag doubles as upstream busy.
// Assumes capture and drain are never requested together and that capture
// only happens while the buffer is empty.
module skid_side_buf #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             drain,
    input  logic [WIDTH-1:0] din,
    output logic             held_vld,
    output logic [WIDTH-1:0] held_dat
);

    // Occupancy flag: set on capture, cleared on drain.
    always_ff @(posedge clk) begin
        if (!rst_n)     held_vld <= 1'b0;
        else if (cap)   held_vld <= 1'b1;
        else if (drain) held_vld <= 1'b0;
    end

    // Data holder: loads only on capture.
    always_ff @(posedge clk) begin
        if (cap) held_dat <= din;
    end

    // R8
    side_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> !held_vld);

    // R9
    side_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_vld && !drain) |=> (held_vld && $stable(held_dat)));

endmodule

// File: rtl/skid_out_reg.sv
// Module skid_out_reg
// Output register toward downstream. It advances when empty or when the
// consumer is not busy; otherwise it holds strobe and data unchanged.
// Assumes nxt_vld/nxt_dat are meaningful only on advancing edges.
module skid_out_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nxt_vld,
    input  logic [WIDTH-1:0] nxt_dat,
    input  logic             dn_busy,
    output logic             advance,
    output logic             vld,
    output logic [WIDTH-1:0] dat
);

    // Register may take a new word when empty or handing off this edge.
    always_comb advance = !vld || !dn_busy;

    // Strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n)       vld <= 1'b0;
        else if (advance) vld <= nxt_vld;
    end

    // Data register: loads only with a valid word.
    always_ff @(posedge clk) begin
        if (advance && nxt_vld) dat <= nxt_dat;
    end

    // R5
    out_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && dn_busy) |=> (vld && $stable(dat)));

endmodule

// File: rtl/skid_stage.sv
// Module skid_stage
// Registered pipeline stage with strobe/busy handshakes on both sides and
// a one-entry side buffer that absorbs the word already in flight when the
// downstream stalls. Upstream busy is the registered side-buffer flag.
// Assumes upstream honours up_busy from the edge after it rises.
module skid_stage
    import skid_stage_pkg::*;
#(
    parameter int               WIDTH    = 16,
    parameter xf_op_e           XF_OP    = XF_ADD,
    parameter logic [WIDTH-1:0] XF_CONST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic [WIDTH-1:0] up_data,
    output logic             up_busy,
    output logic             dn_valid,
    output logic [WIDTH-1:0] dn_data,
    input  logic             dn_busy
);

    logic [WIDTH-1:0] xf_dat;
    logic             side_vld;
    logic [WIDTH-1:0] side_dat;
    logic             advance;
    logic             accept;
    logic             cap;
    logic             drain;
    logic             nxt_vld;
    logic [WIDTH-1:0] nxt_dat;

    skid_xform #(
        .WIDTH    (WIDTH),
        .XF_OP    (XF_OP),
        .XF_CONST (XF_CONST)
    ) u_xform (
        .din  (up_data),
        .dout (xf_dat)
    );

    // Handshake steering: accept, park, drain and output source.
    always_comb begin
        accept  = up_valid && !side_vld;
        cap     = accept && !advance;
        drain   = side_vld && advance;
        nxt_vld = side_vld || accept;
        nxt_dat = side_vld ? side_dat : xf_dat;
    end

    skid_side_buf #(
        .WIDTH (WIDTH)
    ) u_side (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .drain    (drain),
        .din      (xf_dat),
        .held_vld (side_vld),
        .held_dat (side_dat)
    );

    skid_out_reg #(
        .WIDTH (WIDTH)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt_vld (nxt_vld),
        .nxt_dat (nxt_dat),
        .dn_busy (dn_busy),
        .advance (advance),
        .vld     (dn_valid),
        .dat     (dn_data)
    );

    // Upstream busy is the registered side-buffer flag.
    always_comb up_busy = side_vld;

    // R3
    stream_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_busy && (!dn_valid || !dn_busy)) |=> dn_valid);

    // R6
    stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_busy && dn_valid && dn_busy) |=> up_busy);

    // R7
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_busy && !dn_busy) |=> (!up_busy && dn_valid && dn_data == $past(side_dat)));

    // R10
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_busy && !up_valid && !up_busy) |=> !dn_valid);

endmodule

// File: tb/skid_stage_test.sv
// Directed bench for skid_stage with an ordered scoreboard.
module skid_stage_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         up_valid;
    logic [W-1:0] up_data;
    logic         up_busy;
    logic         dn_valid;
    logic [W-1:0] dn_data;
    logic         dn_busy;

    int n_checks = 0;
    int n_fails  = 0;
    int n_cycles = 0;
    bit done     = 1'b0;

    logic [W-1:0] exp_q [0:255];
    int wr_idx = 0;
    int rd_idx = 0;
    bit sb_on  = 1'b0;

    skid_stage uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .up_data  (up_data),
        .up_busy  (up_busy),
        .dn_valid (dn_valid),
        .dn_data  (dn_data),
        .dn_busy  (dn_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) n_cycles <= n_cycles + 1;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard: at mid-cycle the handshake for the coming edge is settled.
    always @(negedge clk) begin
        if (sb_on && rst_n) begin
            // R2 R4: a word enters only when strobe high and busy low
            if (up_valid && !up_busy) begin
                exp_q[wr_idx % 256] = up_data + 16'd1;
                wr_idx++;
            end
            // R8: each hand-off matches the oldest accepted word
            if (dn_valid && !dn_busy) begin
                if (rd_idx >= wr_idx)
                    check(1'b0, "R8 extra word", dn_data, 16'h0);
                else begin
                    check(dn_data == exp_q[rd_idx % 256], "R8 order", dn_data,
                          exp_q[rd_idx % 256]);
                    rd_idx++;
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic drain_all();
        up_valid = 1'b0;
        dn_busy  = 1'b0;
        for (int i = 0; i < 4; i++) cyc();
        check(wr_idx == rd_idx, "R8 all delivered", W'(rd_idx), W'(wr_idx));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; up_valid = 1'b1; up_data = 16'h1234; dn_busy = 1'b1;
        cyc(); cyc(); cyc();
        check(dn_valid == 1'b0, "R1 dn_valid", W'(dn_valid), 16'h0);
        check(up_busy == 1'b0, "R1 up_busy", W'(up_busy), 16'h0);
        up_valid = 1'b0; dn_busy = 1'b0;
        rst_n = 1'b1;
        sb_on = 1'b1;
        cyc();
        check(dn_valid == 1'b0, "R1 idle after reset", W'(dn_valid), 16'h0);
    endtask

    task automatic t_stall_burst();
        dn_busy = 1'b1; up_valid = 1'b0;
        cyc(); cyc();
        dn_busy = 1'b0; up_valid = 1'b1; up_data = 16'd5;
        cyc();
        check(dn_valid && dn_data == 16'd6, "R3 first word", dn_data, 16'd6);
        up_data = 16'd7; cyc();
        check(dn_data == 16'd8, "R3 second word", dn_data, 16'd8);
        up_data = 16'd2; cyc();
        check(dn_data == 16'd3, "R3 third word", dn_data, 16'd3);
        dn_busy = 1'b1; up_data = 16'd9; cyc();
        check(up_busy == 1'b1, "R6 busy raised", W'(up_busy), 16'h1);
        check(dn_valid && dn_data == 16'd3, "R5 held", dn_data, 16'd3);
        up_valid = 1'b0; up_data = 16'd12; cyc();
        check(dn_valid && dn_data == 16'd3, "R5 still held", dn_data, 16'd3);
        up_data = 16'd32; dn_busy = 1'b0; cyc();
        check(up_busy == 1'b0, "R7 busy cleared", W'(up_busy), 16'h0);
        check(dn_valid && dn_data == 16'd10, "R7 buffered word out", dn_data, 16'd10);
        cyc();
        check(dn_valid == 1'b0, "R10 strobe drops", W'(dn_valid), 16'h0);
        drain_all();
    endtask

    task automatic t_stream();
        logic [W-1:0] v;
        dn_busy = 1'b0; up_valid = 1'b1;
        v = 16'hFFF6;
        for (int i = 0; i < 20; i++) begin
            up_data = v;
            cyc();
            check(dn_valid && dn_data == v + 16'd1, "R3 R4 stream", dn_data, v + 16'd1);
            check(up_busy == 1'b0, "R3 no stall", W'(up_busy), 16'h0);
            v = v + 16'd1;
        end
        up_data = 16'hFFFF; cyc();
        check(dn_data == 16'h0000, "R4 wrap", dn_data, 16'h0000);
        drain_all();
    endtask

    task automatic t_ignored();
        up_valid = 1'b0; dn_busy = 1'b0;
        for (int i = 0; i < 3; i++) begin
            up_data = 16'h0A00 + 16'(i);
            cyc();
            check(dn_valid == 1'b0, "R9 strobe low ignored", W'(dn_valid), 16'h0);
        end
        up_valid = 1'b1; up_data = 16'h0100; cyc();
        dn_busy = 1'b1; up_data = 16'h0200; cyc();
        check(up_busy == 1'b1, "R6 parked", W'(up_busy), 16'h1);
        up_data = 16'h0300; cyc();
        up_data = 16'h0400; cyc();
        up_valid = 1'b0; dn_busy = 1'b0; cyc();
        check(dn_data == 16'h0201, "R9 R7 parked word kept", dn_data, 16'h0201);
        cyc();
        check(dn_valid == 1'b0, "R9 no stray word", W'(dn_valid), 16'h0);
        drain_all();
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            up_valid = lfsr[0] | lfsr[3];
            dn_busy  = lfsr[5] & lfsr[1];
            up_data  = lfsr ^ 16'(i);
            cyc();
        end
        drain_all();
    endtask

    initial begin
        up_valid = 1'b0; up_data = '0; dn_busy = 1'b0; rst_n = 1'b0;
        t_reset();
        t_stall_burst();
        t_stream();
        t_ignored();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        wait (n_cycles >= WATCHDOG);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", n_cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule